// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block takes an asynchronous serial receive line and recovers bytes from it. The line first passes through a resynchronizing flop chain. A finite state machine then runs on a one-cycle enable tick at sixteen times the bit rate. It finds the falling edge that opens a frame and confirms it half a bit later. It then takes each data bit at its centre and checks the closing bit.

When a frame closes correctly, the byte goes into a holding register and a data-available flag is raised for the processor. A one-cycle read strobe from the processor lowers the flag. A byte that arrives before the previous one was read replaces it. Frames with a bad closing bit are dropped without a trace.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, `avail_o` is 0, `data_o` is 0, and the receiver waits in idle for a line that is high.
- R2: `rxd_i` reaches the frame logic only through a two-stage synchronizer whose flops reset to 1, so the frame logic sees the line exactly two clock cycles late.
- R3: A low level that is gone when the line is re-checked 8 ticks after the detected falling edge counts as a glitch. It delivers no byte, and the receiver goes back to searching for an edge.
- R4: A frame is one low start bit, then eight data bits with bit 0 first, then one high stop bit. Each data bit is taken 16 ticks after the previous sample point, and all 256 byte values are recovered unchanged.
- R5: If the stop bit samples low, the byte is dropped, and both `avail_o` and `data_o` keep their values. The receiver waits for the line to go high before it looks for a new start edge.
- R6: A frame with a high stop bit puts its byte on `data_o` and sets `avail_o` to 1.
- R7: A cycle with `rd_i` high and no byte arriving clears `avail_o` on the next clock edge.
- R8: A new byte replaces an unread byte on `data_o`, and `avail_o` stays 1.
- R9: The receive state changes only in cycles where `tick_i` is high. A frame sent while ticks are stopped yields nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable at 16x the bit rate |
| rxd_i | input | 1 | Asynchronous serial receive line, idle high |
| rd_i | input | 1 | Processor read strobe for the receive buffer |
| data_o | output | 8 | Last byte received |
| avail_o | output | 1 | Receive data available |

## Verification
The bench sends every byte value as a frame and pairs each one with a read, so a mistake in bit order or in sample spacing shows up as a wrong byte. If the half-bit re-check were missing, a short low pulse would produce a spurious 0xFF. A frame with a low stop bit is followed at once by an idle-high line. A receiver that kept the byte, or that restarted the edge search on the still-low line, would raise the flag or show changed data. The bench also sends two bytes with no read between them, and a whole frame while ticks are stopped. These catch a receiver that keeps the first byte, or one that runs without the enable tick.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_BREAK
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk2
      logic [1:0] settle_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              settle_q <= '0;
        else if (settle_q != 2'd2) settle_q <= settle_q + 2'd1;
      end
      assert_sync_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (settle_q == 2'd2) |-> (q_o == $past(d_i, 2)));
    end
  endgenerate
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_os_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS  = 8,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 line_i,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 valid_o
);
  localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
  localparam int unsigned BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_BITS - 1);

  rx_state_e            state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [BIT_W-1:0]     bit_q;
  logic [DATA_BITS-1:0] shift_q;
  logic                 valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            cnt_q <= '0;
            if (!line_i) state_q <= ST_START;
          end
          ST_START: begin
            if (cnt_q == HALF_LAST) begin
              cnt_q   <= '0;
              bit_q   <= '0;
              state_q <= line_i ? ST_IDLE : ST_DATA;  // high again: glitch
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt_q == FULL_LAST) begin
              cnt_q   <= '0;
              shift_q <= {line_i, shift_q[DATA_BITS-1:1]};  // first bit ends at LSB
              bit_q   <= bit_q + 1'b1;
              if (bit_q == BIT_LAST) state_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == FULL_LAST) begin
              cnt_q <= '0;
              if (line_i) begin
                valid_q <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_BREAK;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_BREAK: begin
            if (line_i) state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign byte_o  = shift_q;
  assign valid_o = valid_q;

  assert_hold_without_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(state_q) && $stable(cnt_q) && !valid_q));
  assert_valid_needs_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == ST_STOP && cnt_q == FULL_LAST && !line_i) |=> !valid_q);
  assert_glitch_to_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == ST_START && cnt_q == HALF_LAST && line_i) |=> state_q == ST_IDLE);
  assert_break_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BREAK && !line_i) |=> state_q == ST_BREAK);
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] byte_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] data_o,
  output logic             avail_o
);
  logic [WIDTH-1:0] data_q;
  logic             avail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      avail_q <= 1'b0;
    end else if (valid_i) begin
      data_q  <= byte_i;  // overwrites any unread byte
      avail_q <= 1'b1;
    end else if (rd_i) begin
      avail_q <= 1'b0;
    end
  end

  assign data_o  = data_q;
  assign avail_o = avail_q;

  assert_load_sets_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (avail_o && data_o == $past(byte_i)));
  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !valid_i) |=> !avail_o);
  assert_data_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  assert_flag_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(avail_o) |-> $past(valid_i));
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 rxd_i,
  input  logic                 rd_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 avail_o
);
  logic                 line_s;
  logic [DATA_BITS-1:0] frame_byte;
  logic                 frame_valid;

  rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line_s)
  );

  rx_frame #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .line_i (line_s),
    .byte_o (frame_byte),
    .valid_o(frame_valid)
  );

  rx_buffer #(.WIDTH(DATA_BITS)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(frame_valid),
    .byte_i (frame_byte),
    .rd_i   (rd_i),
    .data_o (data_o),
    .avail_o(avail_o)
  );
endmodule

// File: tb/uart_os_rx_bench.sv
module uart_os_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic       tick_en = 1'b1;
  logic       rxd = 1'b1;
  logic       rd = 1'b0;
  logic [7:0] data;
  logic       avail;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_os_rx u_uart_os_rx (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .rxd_i  (rxd),
    .rd_i   (rd),
    .data_o (data),
    .avail_o(avail)
  );

  initial forever begin
    @(negedge clk);
    tick <= tick_en ? ~tick : 1'b0;
  end

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    hold(1'b0, BIT_CLKS);
    for (int i = 0; i < 8; i++) hold(b[i], BIT_CLKS);
    hold(stop, BIT_CLKS);
    hold(1'b1, 8);
  endtask

  task automatic do_read();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 avail", {8'h0, avail}, 9'h0);
    chk("R1 data", {1'b0, data}, 9'h0);

    for (int b = 0; b < 256; b++) begin
      send_frame(8'(b), 1'b1);
      chk("R2/R4 data", {1'b0, data}, {1'b0, 8'(b)});
      chk("R6 avail", {8'h0, avail}, 9'h1);
      do_read();
      chk("R7 avail", {8'h0, avail}, 9'h0);
    end

    hold(1'b0, 6);
    hold(1'b1, 3 * BIT_CLKS);
    chk("R3 avail", {8'h0, avail}, 9'h0);
    chk("R3 data", {1'b0, data}, 9'h0ff);
    send_frame(8'h5a, 1'b1);
    chk("R3 data", {1'b0, data}, 9'h05a);
    do_read();

    send_frame(8'h33, 1'b0);
    hold(1'b1, 3 * BIT_CLKS);
    chk("R5 avail", {8'h0, avail}, 9'h0);
    chk("R5 data", {1'b0, data}, 9'h05a);
    send_frame(8'hc4, 1'b1);
    chk("R5 data", {1'b0, data}, 9'h0c4);
    chk("R5 avail", {8'h0, avail}, 9'h1);
    do_read();

    send_frame(8'h11, 1'b1);
    send_frame(8'h22, 1'b1);
    chk("R8 data", {1'b0, data}, 9'h022);
    chk("R8 avail", {8'h0, avail}, 9'h1);
    do_read();
    chk("R7 avail", {8'h0, avail}, 9'h0);

    tick_en = 1'b0;
    send_frame(8'h96, 1'b1);
    tick_en = 1'b1;
    hold(1'b1, 3 * BIT_CLKS);
    chk("R9 avail", {8'h0, avail}, 9'h0);
    chk("R9 data", {1'b0, data}, 9'h022);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule